// File: doc/BRIEF.md
# Cascaded Interrupt Cause Controller

This block collects up to 96 interrupt sources into three groups of 32 and funnels them into a single processor interrupt line. Two main groups take level-sensitive sources from on-chip units. A third group takes general-purpose pins. Each pin's rising edge is caught in a sticky cause bit. The pin group does not reach the processor line directly. Instead it is folded into summary bits inside the upper main group, one summary bit for each 8-bit slice of pins.

Software reads a vector register to learn which source to service. The register returns the number of the highest-priority pending source, or a fixed "bogus" code when nothing qualifies. Selection works in three steps:

- The lower main group is searched first.
- The upper main group is searched only when the lower one has nothing.
- If the upper pick is a pin summary, the search moves on to the pin group.

Each main group also carries a fixed constant of bit positions that may ever be reported. When a vector read returns a pin source, that pin's cause bit is cleared by the read itself. Pin cause bits can also be cleared by writing zeros to them.

Top module: `cic_top`

## Requirements
- R1: After reset:
  - the lower and pin masks are 0 and the upper mask is 0x0F000000;
  - the pin cause register is 0 and `cpu_irq` is low.
- R2: Register addresses are: 0 lower cause, 1 upper cause, 2 pin cause, 3 lower mask, 4 upper mask, 5 pin mask, 6 vector.
  - A read strobe returns data on `bus_rdata` one cycle later.
  - Mask registers read back what was written.
  - Address 7 reads as 0.
- R3: A lower-group bit qualifies only if it is set in the source, set in the constant 0x3DFFFFFE, and set in the lower mask. The highest qualifying bit index is returned as the vector.
- R4: When any lower bit qualifies, it is returned regardless of the upper group.
- R5: An upper-group bit qualifies only if it is set in the cause, set in the constant 0x0F000DB7, and set in the upper mask. A qualifying bit below position 24 is returned as its index plus 32.
- R6: A pin cause bit is set by a 0-to-1 transition of its pin. A pin held high does not set it again after it has been cleared.
- R7: Upper cause bit 24+k reads as the OR of pin cause bits 8k+7 down to 8k, for k = 0 to 3. The upper source inputs at positions 24 and above are ignored.
- R8: When the selected upper bit is at position 24 or above:
  - the vector is 64 plus the highest bit set in (pin cause AND pin mask);
  - if that product is 0, the vector is the bogus code.
- R9: The bogus code is 0xFFFFFFFE. It is returned when nothing qualifies in either main group.
- R10: A write to the pin cause register clears exactly the bits written as 0. A rising edge arriving in the same cycle still sets its bit.
- R11: A vector read that returns a pin source N clears pin cause bit N-64 at the same clock edge.
- R12: `cpu_irq` is the OR of all qualifying bits of both main groups, as defined in R3 and R5.
- R13: The lower and upper cause registers are read-only. Writes to them have no effect, and the lower cause reads the current lower source levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lo | input | 32 | Lower main group source levels |
| src_hi | input | 32 | Upper main group source levels (positions 24 and above ignored) |
| gpp_pin | input | 32 | General-purpose pins, edge-latched |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| cpu_irq | output | 1 | Processor interrupt request |

## Verification
The bench builds the block with its default parameters:

- 32-bit groups;
- the two validity constants;
- the cascade starting at bit 24;
- 8-pin summary slices.

These values make every edge of the numbering reachable. That includes:

- pin source 95 at the top of the range;
- a lower-group request that is masked entirely by the validity constant;
- an upper bit that is unmasked but invalid;
- a pin summary whose pins are all masked, which yields the bogus code.

They also let a single pin change land in the same cycle as a clearing write.

// File: rtl/cic_pkg.sv
package cic_pkg;
   typedef enum logic [2:0] {
      CIC_LO_CAUSE  = 3'd0,
      CIC_HI_CAUSE  = 3'd1,
      CIC_GPP_CAUSE = 3'd2,
      CIC_LO_MASK   = 3'd3,
      CIC_HI_MASK   = 3'd4,
      CIC_GPP_MASK  = 3'd5,
      CIC_VECTOR    = 3'd6,
      CIC_UNUSED    = 3'd7
   } cic_reg_e;
endpackage

// File: rtl/cic_prio_pick.sv
module cic_prio_pick #(
   parameter int W  = 32,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   // Later iterations overwrite earlier ones, so the highest set bit wins.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < W; i++) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/cic_edge_latch.sv
module cic_edge_latch #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin;
   end

   assign rise = pin & ~prev_q;
endmodule

// File: rtl/cic_top.sv
module cic_top
   import cic_pkg::*;
#(
   parameter int          GW          = 32,
   parameter logic [GW-1:0] LO_VALID    = 32'h3DFF_FFFE,
   parameter logic [GW-1:0] HI_VALID    = 32'h0F00_0DB7,
   parameter logic [GW-1:0] HI_MASK_RST = 32'h0F00_0000,
   parameter int          CASCADE_LSB = 24,
   parameter int          SLICE_W     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [GW-1:0] src_lo,
   input  logic [GW-1:0] src_hi,
   input  logic [GW-1:0] gpp_pin,
   input  logic [2:0]    bus_addr,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [GW-1:0] bus_wdata,
   output logic [GW-1:0] bus_rdata,
   output logic          cpu_irq
);
   localparam int IW     = $clog2(GW);
   localparam int SLICES = GW / SLICE_W;
   localparam logic [GW-1:0] BELOW    = GW'((64'd1 << CASCADE_LSB) - 64'd1);
   localparam logic [GW-1:0] HI_BASE  = GW'(GW);
   localparam logic [GW-1:0] GPP_BASE = GW'(2 * GW);
   localparam logic [GW-1:0] BOGUS    = {{(GW-2){1'b1}}, 2'b10};

   // Elaboration-time parameter checks
   if (SLICE_W < 1 || (GW % SLICE_W) != 0) begin : g_bad_slice
      $error("cic_top: SLICE_W must divide GW");
   end
   if (CASCADE_LSB + SLICES > GW) begin : g_bad_cascade
      $error("cic_top: cascade summary bits exceed group width");
   end
   if (GW < 8) begin : g_bad_width
      $error("cic_top: GW too small");
   end

   cic_reg_e addr_e;
   assign addr_e = cic_reg_e'(bus_addr);

   logic [GW-1:0] mask_lo_q, mask_hi_q, mask_gpp_q, gpp_cause_q;
   logic [GW-1:0] gpp_rise, hi_cause;
   logic [SLICES-1:0] summary;

   cic_edge_latch #(.W(GW)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(gpp_pin), .rise(gpp_rise)
   );

   for (genvar k = 0; k < SLICES; k++) begin : g_sum
      assign summary[k] = |gpp_cause_q[k*SLICE_W +: SLICE_W];
   end

   assign hi_cause = (src_hi & BELOW) | (GW'(summary) << CASCADE_LSB);

   logic [GW-1:0] lo_q, hi_q, gpp_q;
   assign lo_q  = src_lo   & LO_VALID & mask_lo_q;
   assign hi_q  = hi_cause & HI_VALID & mask_hi_q;
   assign gpp_q = gpp_cause_q & mask_gpp_q;

   logic          lo_found, hi_found, gpp_found;
   logic [IW-1:0] lo_idx, hi_idx, gpp_idx;

   cic_prio_pick #(.W(GW)) u_pick_lo  (.req(lo_q),  .found(lo_found),  .idx(lo_idx));
   cic_prio_pick #(.W(GW)) u_pick_hi  (.req(hi_q),  .found(hi_found),  .idx(hi_idx));
   cic_prio_pick #(.W(GW)) u_pick_gpp (.req(gpp_q), .found(gpp_found), .idx(gpp_idx));

   logic [GW-1:0] vector;
   logic          vec_gpp_hit;

   always_comb begin
      vector      = BOGUS;
      vec_gpp_hit = 1'b0;
      if (lo_found) begin
         vector = GW'(lo_idx);
      end else if (hi_found) begin
         if (int'(hi_idx) >= CASCADE_LSB) begin
            if (gpp_found) begin
               vector      = GPP_BASE + GW'(gpp_idx);
               vec_gpp_hit = 1'b1;
            end
         end else begin
            vector = HI_BASE + GW'(hi_idx);
         end
      end
   end

   assign cpu_irq = (|lo_q) | (|hi_q);

   logic [GW-1:0] keep;
   always_comb begin
      keep = '1;
      if (bus_wr && addr_e == CIC_GPP_CAUSE) keep = bus_wdata;
      if (bus_rd && addr_e == CIC_VECTOR && vec_gpp_hit)
         keep = keep & ~(GW'(1) << gpp_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_lo_q   <= '0;
         mask_hi_q   <= HI_MASK_RST;
         mask_gpp_q  <= '0;
         gpp_cause_q <= '0;
      end else begin
         gpp_cause_q <= (gpp_cause_q & keep) | gpp_rise;
         if (bus_wr) begin
            case (addr_e)
               CIC_LO_MASK:  mask_lo_q  <= bus_wdata;
               CIC_HI_MASK:  mask_hi_q  <= bus_wdata;
               CIC_GPP_MASK: mask_gpp_q <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         case (addr_e)
            CIC_LO_CAUSE:  bus_rdata <= src_lo;
            CIC_HI_CAUSE:  bus_rdata <= hi_cause;
            CIC_GPP_CAUSE: bus_rdata <= gpp_cause_q;
            CIC_LO_MASK:   bus_rdata <= mask_lo_q;
            CIC_HI_MASK:   bus_rdata <= mask_hi_q;
            CIC_GPP_MASK:  bus_rdata <= mask_gpp_q;
            CIC_VECTOR:    bus_rdata <= vector;
            default:       bus_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/cic_checks.sv
module cic_checks #(
   parameter int GW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    bus_addr,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic [GW-1:0] bus_wdata,
   input logic [GW-1:0] bus_rdata,
   input logic          cpu_irq,
   input logic [GW-1:0] gpp_cause_q,
   input logic [GW-1:0] gpp_rise,
   input logic [GW-1:0] mask_lo_q,
   input logic [GW-1:0] mask_hi_q
);
   localparam int IW = $clog2(GW);
   localparam logic [GW-1:0] BOGUS   = {{(GW-2){1'b1}}, 2'b10};
   localparam logic [GW-1:0] GPP_LO  = GW'(2 * GW);
   localparam logic [GW-1:0] VEC_END = GW'(3 * GW);

   // R12: no main mask bit set -> no interrupt
   p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_lo_q == '0 && mask_hi_q == '0) |-> !cpu_irq);

   // R9: nothing qualifying -> vector read returns bogus
   p_bogus_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 3'd6 && !cpu_irq) |=> (bus_rdata == BOGUS));

   // R3: vector is either a source number or the bogus code
   p_vec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 3'd6) |=> (bus_rdata == BOGUS || bus_rdata < VEC_END));

   // R10: cause write keeps only the bits written as 1, plus new edges
   p_gpp_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd2 && !bus_rd) |=>
      (gpp_cause_q == (($past(gpp_cause_q) & $past(bus_wdata)) | $past(gpp_rise))));

   // R10: an edge always lands in the cause register
   p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gpp_rise != '0) |=> ((gpp_cause_q & $past(gpp_rise)) == $past(gpp_rise)));

   // R6: no cause bit appears without a rising edge
   p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gpp_rise == '0) |=> ((gpp_cause_q & ~$past(gpp_cause_q)) == '0));

   // R11: a returned pin source has its cause bit cleared
   p_vec_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 3'd6 && gpp_rise == '0) |=>
      !(bus_rdata >= GPP_LO && bus_rdata < VEC_END && gpp_cause_q[bus_rdata[IW-1:0]]));
endmodule

bind cic_top cic_checks #(.GW(GW)) u_cic_checks (.*);

// File: tb/tb_cic_top.sv
module tb_cic_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_lo = '0, src_hi = '0, gpp_pin = '0, bus_wdata = '0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        cpu_irq;
   int          n_total = 0, n_pass = 0;
   localparam logic [31:0] BOGUS = 32'hFFFF_FFFE;

   always #10 clk = ~clk;

   cic_top dut (
      .clk(clk), .rst_n(rst_n), .src_lo(src_lo), .src_hi(src_hi),
      .gpp_pin(gpp_pin), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_irq(cpu_irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act === exp) n_pass++;
      else $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
   endtask

   task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic set_pins(input logic [31:0] v);
      @(negedge clk);
      gpp_pin = v;
      @(negedge clk);
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bread(3'd3, d); check("R1 lo mask", d, 32'h0);
      bread(3'd4, d); check("R1 hi mask", d, 32'h0F00_0000);
      bread(3'd5, d); check("R1 pin mask", d, 32'h0);
      bread(3'd2, d); check("R1 pin cause", d, 32'h0);
      check("R1 irq", {31'b0, cpu_irq}, 32'h0);
      bread(3'd6, d); check("R9 idle vector", d, BOGUS);
   endtask

   task automatic t_low();
      logic [31:0] d;
      src_lo = 32'hFFFF_FFFF;
      bwrite(3'd3, 32'hFFFF_FFFF);
      check("R12 irq from low", {31'b0, cpu_irq}, 32'h1);
      bread(3'd6, d); check("R3 highest valid low", d, 32'd29);
      bwrite(3'd3, 32'h4200_0001);
      check("R3 invalid bits no irq", {31'b0, cpu_irq}, 32'h0);
      bread(3'd6, d); check("R3 invalid bits bogus", d, BOGUS);
      src_lo = 32'h0000_0012;
      bwrite(3'd3, 32'hFFFF_FFFF);
      bread(3'd6, d); check("R3 low pick", d, 32'd4);
      bwrite(3'd0, 32'h0);
      bread(3'd0, d); check("R13 lo cause read-only", d, 32'h0000_0012);
      bwrite(3'd1, 32'hFFFF_FFFF);
      bread(3'd1, d); check("R13 hi cause read-only", d, 32'h0);
      bread(3'd3, d); check("R2 mask readback", d, 32'hFFFF_FFFF);
      bwrite(3'd5, 32'h1234_5678);
      bread(3'd5, d); check("R2 pin mask readback", d, 32'h1234_5678);
      bwrite(3'd5, 32'h0);
      bread(3'd7, d); check("R2 unmapped", d, 32'h0);
   endtask

   task automatic t_order();
      logic [31:0] d;
      src_lo = 32'h10; src_hi = 32'h1;
      bwrite(3'd4, 32'hFFFF_FFFF);
      bread(3'd6, d); check("R4 low first", d, 32'd4);
      src_lo = 32'h0;
      bread(3'd6, d); check("R4 high after low empty", d, 32'd32);
      src_hi = 32'h5;
      bread(3'd6, d); check("R5 high pick", d, 32'd34);
      src_hi = 32'h8;
      bread(3'd6, d); check("R5 invalid high bogus", d, BOGUS);
      check("R12 invalid high no irq", {31'b0, cpu_irq}, 32'h0);
      src_hi = 32'h800;
      bread(3'd6, d); check("R5 high bit 11", d, 32'd43);
   endtask

   task automatic t_cascade();
      logic [31:0] d;
      src_hi = 32'h0100_0000;
      bread(3'd1, d); check("R7 source at 24 ignored", d, 32'h0);
      check("R7 no summary irq", {31'b0, cpu_irq}, 32'h0);
      set_pins(32'h200);
      bread(3'd2, d); check("R6 edge latched", d, 32'h200);
      bread(3'd1, d); check("R7 summary slice 1", d, 32'h0200_0000);
      bread(3'd6, d); check("R8 masked pins bogus", d, BOGUS);
      bwrite(3'd5, 32'hFFFF_FFFF);
      bread(3'd6, d); check("R8 pin vector", d, 32'd73);
      bread(3'd2, d); check("R11 read clears", d, 32'h0);
      settle(); settle();
      bread(3'd2, d); check("R6 held pin no reset", d, 32'h0);
   endtask

   task automatic t_clear();
      logic [31:0] d;
      src_hi = 32'h0;
      set_pins(32'h0);
      set_pins(32'h8010_0008);
      bread(3'd2, d); check("R6 three edges", d, 32'h8010_0008);
      bwrite(3'd2, 32'hFFFF_FFF7);
      bread(3'd2, d); check("R10 write-zero clears", d, 32'h8010_0000);
      bread(3'd6, d); check("R8 top source", d, 32'd95);
      bread(3'd2, d); check("R11 bit 31 cleared", d, 32'h0010_0000);
      @(negedge clk);
      gpp_pin = gpp_pin | 32'h20;
      bus_addr = 3'd2; bus_wdata = 32'h0; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      bread(3'd2, d); check("R10 edge beats clear", d, 32'h20);
   endtask

   task automatic t_irq();
      bwrite(3'd3, 32'h0);
      bwrite(3'd4, 32'h0);
      src_hi = 32'h4;
      settle();
      check("R12 all masked", {31'b0, cpu_irq}, 32'h0);
      bwrite(3'd4, 32'h4);
      check("R12 high unmasked", {31'b0, cpu_irq}, 32'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_total++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_low();
      t_order();
      t_cascade();
      t_clear();
      t_irq();
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end
endmodule